// File: doc/BRIEF.md
# Pending Wake Queue With Interrupt

This block gathers wake notifications from many channel backends and presents them to software one channel at a time. Each notification names a 64-bit channel identifier and carries a small set of wake flags: closed, readable and writable. A channel that already waits in the queue is never queued twice. Instead, its flags gather by OR until software services it. While anything is pending, a level interrupt stays high.

Software services the queue through a small read port. A read of the channel-low register removes the newest pending channel, returns the lower half of its identifier, and latches that channel's gathered flags into a wakes register, which software reads next. A read of the channel-high register returns the upper half of the newest channel's identifier and does not disturb the queue. A separate removal port deletes a channel from any position, for use when the channel is torn down. When the far side hangs up a channel, it posts a notification with the closed flag forced on.

Top module: `wake_queue`

## Requirements
- R1: After reset the queue is empty, `irq_o` is low, and reads at every address return 0.
- R2: A notification for a channel not in the queue inserts it at the head, so channels are serviced newest-first.
- R3: A notification for a channel already in the queue ORs its flags into that entry and leaves the entry's position unchanged. Each channel appears at most once.
- R4: `irq_o` is high in the cycle after any notification and stays high while the queue holds an entry.
- R5: A read at address 0 with a non-empty queue returns bits 31:0 of the head identifier and removes the head. It also latches the head's flags into the wakes register at address 2 (bit 0 closed, bit 1 readable, bit 2 writable, upper bits 0). A channel queued again later carries only its new flags.
- R6: A read at address 1 returns bits 63:32 of the head identifier and leaves the queue unchanged.
- R7: With an empty queue, reads at addresses 0 and 1 return 0 and change neither the queue nor the wakes register. Address 3 always reads 0.
- R8: `irq_o` falls in the cycle after a pop or a removal empties the queue.
- R9: A notification with `ev_hangup_i` set queues the channel with the closed flag (bit 0) set, together with any flags it carries.
- R10: A removal request deletes the matching entry wherever it sits and keeps the order of the others. A removal for a channel not in the queue has no effect.
- R11: When events coincide in one cycle, they apply in this order: pop, then removal, then notification.
- R12: When all DEPTH entries are in use, a notification for a new channel is dropped. A notification for a queued channel still merges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid_i | input | 1 | Wake notification strobe |
| ev_chan_i | input | ID_W | Channel identifier of the notification |
| ev_flags_i | input | 3 | Wake flags: bit 0 closed, bit 1 readable, bit 2 writable |
| ev_hangup_i | input | 1 | Notification is a hang-up; forces the closed flag |
| rm_valid_i | input | 1 | Removal request strobe |
| rm_chan_i | input | ID_W | Channel identifier to remove |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address: 0 channel low (pops), 1 channel high, 2 wakes, 3 reserved |
| rd_data_o | output | 32 | Read data for the current address, valid in the cycle of the strobe |
| irq_o | output | 1 | Level interrupt, high while the queue is non-empty |

## Verification
Corrupted queue state appears at the ports only at the next pop. A lost, duplicated or misordered entry shows up as a wrong identifier at address 0. Flags that were merged wrongly, or not cleared, show up as a wrong value at address 2 right after that pop. A broken valid chain shows up as `irq_o` staying high, or falling early, in the cycle after the last pop. Every scenario therefore drains the queue completely, so any stale entry is exposed within DEPTH reads.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int FLG_W = 3;
  localparam int FLG_CLOSED = 0;
  localparam int FLG_READ = 1;
  localparam int FLG_WRITE = 2;

  typedef enum logic [1:0] {
    RA_CHAN_LO = 2'd0,
    RA_CHAN_HI = 2'd1,
    RA_WAKES   = 2'd2,
    RA_NONE    = 2'd3
  } rd_addr_e;
endpackage

// File: rtl/wq_locate.sv
module wq_locate #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 64
) (
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0][ID_W-1:0] ids,
  input  logic [ID_W-1:0]            key,
  output logic                       hit,
  output logic [DEPTH-1:0]           sel,
  output logic [DEPTH-1:0]           from_sel
);
  // one comparator per slot; the queue keeps identifiers unique
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign sel[g] = vld[g] && (ids[g] == key);
  end

  // mark the matched slot and every slot behind it
  always_comb begin
    from_sel[0] = sel[0];
    for (int i = 1; i < DEPTH; i++) begin
      from_sel[i] = from_sel[i-1] | sel[i];
    end
    hit = |sel;
  end
endmodule

// File: rtl/wq_regmux.sv
module wq_regmux
  import wq_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic [1:0]      addr,
  input  logic            head_vld,
  input  logic [ID_W-1:0] head_id,
  input  logic [FLG_W-1:0] wakes,
  output logic [31:0]     data
);
  logic [63:0] id_wide;
  assign id_wide = 64'(head_id);

  always_comb begin
    data = '0;
    case (rd_addr_e'(addr))
      RA_CHAN_LO: if (head_vld) data = id_wide[31:0];
      RA_CHAN_HI: if (head_vld) data = id_wide[63:32];
      RA_WAKES:   data = 32'(wakes);
      default:    data = '0;
    endcase
  end
endmodule

// File: rtl/wake_queue.sv
module wake_queue
  import wq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid_i,
  input  logic [ID_W-1:0]  ev_chan_i,
  input  logic [FLG_W-1:0] ev_flags_i,
  input  logic             ev_hangup_i,
  input  logic             rm_valid_i,
  input  logic [ID_W-1:0]  rm_chan_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_addr_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_o
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // queue state: slot 0 is the head, valid slots are packed from 0
  logic [DEPTH-1:0]                  q_vld;
  logic [DEPTH-1:0][ID_W-1:0]        q_id;
  logic [DEPTH-1:0][FLG_W-1:0]       q_flg;
  logic [FLG_W-1:0]                  wakes_q;

  logic [DEPTH-1:0]                  q_vld_d;
  logic [DEPTH-1:0][ID_W-1:0]        q_id_d;
  logic [DEPTH-1:0][FLG_W-1:0]       q_flg_d;
  logic [FLG_W-1:0]                  wakes_d;
  logic                              q_en;

  // stage 1: pop
  logic                              pop;
  logic [DEPTH:0]                    s1x_vld;
  logic [DEPTH:0][ID_W-1:0]          s1x_id;
  logic [DEPTH:0][FLG_W-1:0]         s1x_flg;
  // stage 2: removal
  logic                              rm_hit;
  logic [DEPTH-1:0]                  rm_sel, rm_from;
  logic [DEPTH-1:0]                  s2_vld;
  logic [DEPTH-1:0][ID_W-1:0]        s2_id;
  logic [DEPTH-1:0][FLG_W-1:0]       s2_flg;
  // stage 3: notification
  logic                              evt;
  logic [FLG_W-1:0]                  evt_flg;
  logic                              ev_hit;
  logic [DEPTH-1:0]                  ev_sel, ev_from;

  assign pop     = rd_en_i && (rd_addr_i == RA_CHAN_LO) && q_vld[0];
  assign evt     = ev_valid_i || ev_hangup_i;
  assign evt_flg = ev_flags_i | (ev_hangup_i ? FLG_W'(1 << FLG_CLOSED) : '0);

  always_comb begin
    s1x_vld[DEPTH] = 1'b0;
    s1x_id[DEPTH]  = '0;
    s1x_flg[DEPTH] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s1x_vld[i] = pop ? ((i == DEPTH-1) ? 1'b0 : q_vld[(i+1) % DEPTH]) : q_vld[i];
      s1x_id[i]  = pop ? q_id[(i+1) % DEPTH]  : q_id[i];
      s1x_flg[i] = pop ? q_flg[(i+1) % DEPTH] : q_flg[i];
    end
  end

  wq_locate #(.DEPTH(DEPTH), .ID_W(ID_W)) u_rm_loc (
    .vld      (s1x_vld[DEPTH-1:0]),
    .ids      (s1x_id[DEPTH-1:0]),
    .key      (rm_chan_i),
    .hit      (rm_hit),
    .sel      (rm_sel),
    .from_sel (rm_from)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rm_valid_i && rm_hit && rm_from[i]) begin
        s2_vld[i] = s1x_vld[i+1];
        s2_id[i]  = s1x_id[i+1];
        s2_flg[i] = s1x_flg[i+1];
      end else begin
        s2_vld[i] = s1x_vld[i];
        s2_id[i]  = s1x_id[i];
        s2_flg[i] = s1x_flg[i];
      end
    end
  end

  wq_locate #(.DEPTH(DEPTH), .ID_W(ID_W)) u_ev_loc (
    .vld      (s2_vld),
    .ids      (s2_id),
    .key      (ev_chan_i),
    .hit      (ev_hit),
    .sel      (ev_sel),
    .from_sel (ev_from)
  );

  always_comb begin
    q_vld_d = s2_vld;
    q_id_d  = s2_id;
    q_flg_d = s2_flg;
    if (evt && ev_hit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ev_sel[i]) q_flg_d[i] = s2_flg[i] | evt_flg;
      end
    end else if (evt && !s2_vld[DEPTH-1]) begin
      q_vld_d[0] = 1'b1;
      q_id_d[0]  = ev_chan_i;
      q_flg_d[0] = evt_flg;
      for (int i = 1; i < DEPTH; i++) begin
        q_vld_d[i] = s2_vld[i-1];
        q_id_d[i]  = s2_id[i-1];
        q_flg_d[i] = s2_flg[i-1];
      end
    end
  end

  assign q_en    = pop || rm_valid_i || evt;
  assign wakes_d = pop ? q_flg[0] : wakes_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_vld   <= '0;
      q_id    <= '0;
      q_flg   <= '0;
      wakes_q <= '0;
    end else begin
      if (q_en) begin
        q_vld <= q_vld_d;
        q_id  <= q_id_d;
        q_flg <= q_flg_d;
      end
      if (pop) wakes_q <= wakes_d;
    end
  end

  wq_regmux #(.ID_W(ID_W)) u_mux (
    .addr     (rd_en_i ? rd_addr_i : RA_NONE),
    .head_vld (q_vld[0]),
    .head_id  (q_id[0]),
    .wakes    (wakes_q),
    .data     (rd_data_o)
  );

  assign irq_o = q_vld[0];

  // the sel vectors are not needed beyond the locate blocks
  logic unused_sel;
  assign unused_sel = ^{rm_sel, ev_from};
endmodule

// File: rtl/wq_checker.sv
module wq_checker
  import wq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 64
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        ev_valid_i,
  input logic                        ev_hangup_i,
  input logic                        rm_valid_i,
  input logic                        rd_en_i,
  input logic [1:0]                  rd_addr_i,
  input logic [31:0]                 rd_data_o,
  input logic                        irq_o,
  input logic                        pop,
  input logic [DEPTH-1:0]            q_vld,
  input logic [DEPTH-1:0][ID_W-1:0]  q_id,
  input logic [DEPTH-1:0][FLG_W-1:0] q_flg,
  input logic [FLG_W-1:0]            wakes_q
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = i + 1; j < DEPTH; j++)
        if (q_vld[i] && q_vld[j] && q_id[i] == q_id[j]) dup = 1'b1;
  end

  // R3: no channel is held twice
  assert_unique_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dup);

  // R2: valid entries stay packed from the head
  assert_packed_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    &(~q_vld[DEPTH-1:1] | q_vld[DEPTH-2:0]));

  // R4: any notification leaves the interrupt high
  assert_wake_irq_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_valid_i || ev_hangup_i) |=> irq_o);

  // R7: empty reads of the channel registers give zero
  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_i && !irq_o && rd_addr_i != RA_WAKES) |-> rd_data_o == 32'd0);

  // R5: a pop latches the head flags
  assert_pop_latch_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop |=> wakes_q == $past(q_flg[0]));

  // R8: the interrupt only falls after a pop or removal
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_o) |-> $past(pop || rm_valid_i));
endmodule

bind wake_queue wq_checker #(.DEPTH(DEPTH), .ID_W(ID_W)) u_wq_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .ev_valid_i  (ev_valid_i),
  .ev_hangup_i (ev_hangup_i),
  .rm_valid_i  (rm_valid_i),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .pop         (pop),
  .q_vld       (q_vld),
  .q_id        (q_id),
  .q_flg       (q_flg),
  .wakes_q     (wakes_q)
);

// File: tb/tb_wake_queue.sv
module tb_wake_queue;
  localparam int DEPTH = 4;
  localparam int ID_W  = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_valid_i, ev_hangup_i, rm_valid_i, rd_en_i;
  logic [ID_W-1:0] ev_chan_i, rm_chan_i;
  logic [2:0] ev_flags_i;
  logic [1:0] rd_addr_i;
  logic [31:0] rd_data_o;
  logic irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_queue #(.DEPTH(DEPTH), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid_i(ev_valid_i), .ev_chan_i(ev_chan_i), .ev_flags_i(ev_flags_i),
    .ev_hangup_i(ev_hangup_i), .rm_valid_i(rm_valid_i), .rm_chan_i(rm_chan_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  localparam logic [63:0] CA = 64'h1111_0001_0000_00A1;
  localparam logic [63:0] CB = 64'h2222_0002_0000_00B2;
  localparam logic [63:0] CC = 64'h3333_0003_0000_00C3;
  localparam logic [63:0] CD = 64'h4444_0004_0000_00D4;
  localparam logic [63:0] CE = 64'h5555_0005_0000_00E5;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic re, input logic [1:0] ra,
                     input logic ev, input logic [63:0] ec, input logic [2:0] ef,
                     input logic hg, input logic rm, input logic [63:0] rc,
                     output logic [31:0] rd);
    @(negedge clk);
    rd_en_i = re; rd_addr_i = ra;
    ev_valid_i = ev; ev_chan_i = ec; ev_flags_i = ef; ev_hangup_i = hg;
    rm_valid_i = rm; rm_chan_i = rc;
    #1 rd = rd_data_o;
    @(posedge clk);
    #1;
    rd_en_i = 0; ev_valid_i = 0; ev_hangup_i = 0; rm_valid_i = 0;
  endtask

  task automatic wake(input logic [63:0] ch, input logic [2:0] f);
    logic [31:0] d;
    cyc(0, 0, 1, ch, f, 0, 0, 0, d);
  endtask

  task automatic hang(input logic [63:0] ch, input logic [2:0] f);
    logic [31:0] d;
    cyc(0, 0, 0, ch, f, 1, 0, 0, d);
  endtask

  task automatic remove(input logic [63:0] ch);
    logic [31:0] d;
    cyc(0, 0, 0, 0, 0, 0, 1, ch, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cyc(1, a, 0, 0, 0, 0, 0, 0, d);
  endtask

  task automatic pop_expect(input string tag, input logic [63:0] ch, input logic [2:0] f);
    logic [31:0] d;
    rd(2'd0, d);
    check({tag, " pop id"}, {32'd0, d}, {32'd0, ch[31:0]});
    rd(2'd2, d);
    check({tag, " wakes"}, {32'd0, d}, {61'd0, f});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq after reset", {63'd0, irq_o}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 R7 read after reset", {32'd0, d}, 64'd0);
    end
  endtask

  task automatic t_lifo;
    logic [31:0] d;
    wake(CA, 3'b010); wake(CB, 3'b100); wake(CC, 3'b010);
    check("R4 irq pending", {63'd0, irq_o}, 64'd1);
    rd(2'd1, d); check("R6 high word", {32'd0, d}, {32'd0, CC[63:32]});
    rd(2'd1, d); check("R6 no pop", {32'd0, d}, {32'd0, CC[63:32]});
    pop_expect("R2 R5 first", CC, 3'b010);
    pop_expect("R2 R5 second", CB, 3'b100);
    pop_expect("R2 R5 third", CA, 3'b010);
    check("R8 irq drained", {63'd0, irq_o}, 64'd0);
    rd(2'd0, d); check("R7 empty low", {32'd0, d}, 64'd0);
    rd(2'd1, d); check("R7 empty high", {32'd0, d}, 64'd0);
    rd(2'd2, d); check("R7 wakes kept", {32'd0, d}, 64'd2);
  endtask

  task automatic t_merge;
    wake(CA, 3'b010); wake(CB, 3'b100); wake(CA, 3'b100);
    pop_expect("R3 order kept", CB, 3'b100);
    pop_expect("R3 merged", CA, 3'b110);
    wake(CA, 3'b010);
    pop_expect("R5 flags cleared", CA, 3'b010);
  endtask

  task automatic t_hangup;
    hang(CD, 3'b000);
    check("R9 irq", {63'd0, irq_o}, 64'd1);
    pop_expect("R9 closed only", CD, 3'b001);
    hang(CD, 3'b010);
    pop_expect("R9 closed with read", CD, 3'b011);
  endtask

  task automatic t_remove;
    wake(CA, 3'b010); wake(CB, 3'b010); wake(CC, 3'b100);
    remove(CB);
    remove(CE);
    pop_expect("R10 after middle removal", CC, 3'b100);
    check("R10 irq one left", {63'd0, irq_o}, 64'd1);
    remove(CA);
    check("R8 irq after removal", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wake(CA, 3'b010);
    cyc(1, 2'd0, 1, CA, 3'b100, 0, 0, 0, d);
    check("R11 pop first id", {32'd0, d}, {32'd0, CA[31:0]});
    rd(2'd2, d); check("R11 pop first wakes", {32'd0, d}, 64'd2);
    check("R11 irq reinserted", {63'd0, irq_o}, 64'd1);
    pop_expect("R11 reinserted fresh", CA, 3'b100);
    wake(CB, 3'b010);
    cyc(0, 2'd0, 1, CB, 3'b100, 0, 1, CB, d);
    pop_expect("R11 remove before wake", CB, 3'b100);
    check("R11 drained", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_full;
    logic [31:0] d;
    wake(CA, 3'b010); wake(CB, 3'b010); wake(CC, 3'b010); wake(CD, 3'b010);
    wake(CE, 3'b100);
    wake(CB, 3'b100);
    pop_expect("R12 full head", CD, 3'b010);
    pop_expect("R12 full 2", CC, 3'b010);
    pop_expect("R12 merge while full", CB, 3'b110);
    pop_expect("R12 full 4", CA, 3'b010);
    rd(2'd0, d); check("R12 dropped channel absent", {32'd0, d}, 64'd0);
    check("R12 irq", {63'd0, irq_o}, 64'd0);
  endtask

  initial begin
    rst_n = 0; rd_en_i = 0; rd_addr_i = 0; ev_valid_i = 0; ev_chan_i = 0;
    ev_flags_i = 0; ev_hangup_i = 0; rm_valid_i = 0; rm_chan_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lifo();
    t_merge();
    t_hangup();
    t_remove();
    t_same_cycle();
    t_full();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule